// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block gives a host processor byte-wide register access to a legacy parallel printer port. The host reaches it over a plain I/O bus with an address, separate read and write strobes and a flag that marks a single-byte access. On the pin side the block drives the output data byte, a data-direction signal and the printer control lines. It samples the printer status lines and the input data lines. It turns an acknowledge pulse from the printer into a level interrupt request.

Enhanced-mode address and data cycles are not timed here. Each one is handed to a pin-side sequencer as a one-clock request with a transfer tag. A plain data write uses the same request path. The block owns the register meaning, the address decode, the forced bits of the control register, the direction handling and the interrupt rules.

Top module: `pport_regblock`

## Requirements
- R1: The block answers only inside its register window. By default the window is eight byte addresses starting at BASE_ADDR (default 0x378). When BASE_ADDR is 0x3BC the window is four addresses. An access outside the window gives no read response and changes no state.
- R2: A write with `bus_byte` low is discarded. A read with `bus_byte` low returns 0xFF and has no side effect; in particular it does not clear the interrupt.
- R3: A byte write to offset 0 stores the byte and drives it on `pin_dout` from the next cycle. In that same cycle it raises `xfer_req` for one clock with tag 0 (plain data write) and the byte on `xfer_wdata`.
- R4: A byte read of offset 0 behaves according to the direction. In forward direction it returns the stored byte. In reverse direction it returns `pin_din` as sampled at the strobe, and that value also replaces the stored byte.
- R5: A byte read of offset 1 returns `pin_status` after a two-flop synchronizer and deasserts `irq`. The status bit meanings are: 7 busy, 6 acknowledge, 5 paper out, 4 selected, 3 error, 2 interrupt, 1 unused, 0 enhanced-cycle timeout.
- R6: The control register at offset 2 always reads with bits 7 and 6 set, and a write forces them to 1. `pin_ctrl` carries bits 4..0: 4 acknowledge-interrupt enable, 3 select, 2 printer init, 1 auto line feed, 0 strobe.
- R7: A control write applies only when its value, with bits 7:6 forced to 1, differs from the stored value. In that case bit 5 sets `pin_dir` (1 = reverse/input, 0 = forward/output), and the value is stored and driven with bit 5 cleared. A write whose forced value equals the stored value changes nothing, and the direction is kept.
- R8: A byte write to offset 3 raises a one-clock `xfer_req` with tag 1 (enhanced address write). A byte write to offset 4 raises one with tag 2 (enhanced data write). In both cases the byte is on `xfer_wdata`.
- R9: A byte read of offset 3 raises a one-clock `xfer_req` with tag 3 (enhanced address read). A byte read of offset 4 raises one with tag 4 (enhanced data read). The block then waits. In the first cycle in which `xfer_ready` is high, `bus_rvalid` is high and `bus_rdata` equals `xfer_rdata`. Bus strobes are ignored while it waits.
- R10: Offsets 5, 6 and 7 ignore writes. A byte read of any of them returns 0xFF with no side effect.
- R11: A rising edge of `pin_ack` sets `irq`, but only while control bit 4 is 1. The edge is seen through a two-flop synchronizer, so `irq` rises on the third clock edge after `pin_ack` rises. `irq` then stays high until a byte status read. An edge seen while bit 4 is 0 is dropped.
- R12: After reset the stored data is 0x00, control reads 0xC0, `pin_dir` is 0, and `irq`, `xfer_req` and `bus_rvalid` are low. Every read except the enhanced reads answers with `bus_rvalid` in the cycle after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_byte | input | 1 | High for a single-byte access |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 8 | Read data |
| pin_dout | output | 8 | Data byte driven to the port |
| pin_din | input | 8 | Data byte sampled from the port |
| pin_dir | output | 1 | 1 = reverse (input), 0 = forward |
| pin_ctrl | output | 5 | Control lines, bits 4..0 of the control register |
| pin_status | input | 8 | Printer status lines |
| pin_ack | input | 1 | Acknowledge notification, asynchronous |
| irq | output | 1 | Interrupt request, level |
| xfer_req | output | 1 | One-clock transfer request to the pin sequencer |
| xfer_tag | output | 3 | Transfer kind: 0 data wr, 1 addr wr, 2 edata wr, 3 addr rd, 4 edata rd |
| xfer_wdata | output | 8 | Byte for write transfers |
| xfer_ready | input | 1 | Read transfer finished |
| xfer_rdata | input | 8 | Byte returned by a read transfer |

## Verification
Register writes and transfer requests become visible in the cycle after the strobe is sampled. Plain reads answer in that same cycle. The bench therefore drives each strobe at a falling edge and samples outputs at the next falling edge. An enhanced read answers in the very cycle `xfer_ready` is raised, so the bench raises ready at a falling edge and samples shortly after, with no clock edge in between. An acknowledge needs three rising edges to reach `irq`. The bench checks `irq` low after the second edge and high after the third.

// File: rtl/pport_pkg.sv
// Shared constants and transfer tag type for the parallel port register block.
package pport_pkg;

    localparam int REG_W = 8;

    // Kind of one-byte transfer handed to the pin-side sequencer
    typedef enum logic [2:0] {
        XF_DATA_WR  = 3'd0,
        XF_EADDR_WR = 3'd1,
        XF_EDATA_WR = 3'd2,
        XF_EADDR_RD = 3'd3,
        XF_EDATA_RD = 3'd4
    } xfer_tag_t;

    // Register offsets inside the window
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_EADDR = 3'd3;
    localparam logic [2:0] OFS_EDATA = 3'd4;

    // Control bit positions
    localparam int CB_REVERSE = 5;
    localparam int CB_ACK_IRQ = 4;

    localparam logic [REG_W-1:0] CTRL_FORCED = 8'hC0;
    localparam logic [REG_W-1:0] BUS_FLOAT   = 8'hFF;

endpackage

// File: rtl/pport_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit may change at any time; bits are not guaranteed coherent.
module pport_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pport_irq.sv
// Turns a synchronized acknowledge level into a held interrupt request.
// A rising edge sets the request when enabled; clear drops it; set wins
// over a clear in the same cycle so no acknowledge is lost.
module pport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic enable,
    input  logic clear,
    output logic irq
);

    logic ack_prev;
    logic irq_q;
    logic set_evt;

    assign set_evt = ack_s && !ack_prev && enable;

    // Remember the last acknowledge level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b0;
        else        ack_prev <= ack_s;
    end

    // Hold the request until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (set_evt) irq_q <= 1'b1;
        else if (clear)   irq_q <= 1'b0;
    end

    assign irq = irq_q;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(enable)); // R11
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clear) |=> irq_q); // R11
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(ack_s && !ack_prev)) |=> !irq_q); // R5

endmodule

// File: rtl/pport_epp_seq.sv
// Tracks an outstanding enhanced read transfer.
// Assumes start is only given when not busy; done is the completion cycle.
module pport_epp_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ready,
    output logic busy,
    output logic done
);

    logic busy_q;

    assign done = busy_q && ready;
    assign busy = busy_q;

    // Busy from the request until the sequencer reports ready
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
        else if (done)  busy_q <= 1'b0;
    end

    AST_EPP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R9
    AST_EPP_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q); // R9

endmodule

// File: rtl/pport_regblock.sv
// Host register block of a legacy parallel port.
// Decodes a window of byte registers. It holds data and control, samples the
// status lines, drives direction and control pins, raises one-clock transfer
// requests for data and enhanced cycles, and produces the interrupt.
// Assumes bus_rd and bus_wr are one-clock strobes and never both high, and
// that pin_din is stable while a reverse data read is strobed.
module pport_regblock #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0378,
    parameter int                SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [7:0]        bus_wdata,
    output logic              bus_rvalid,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        pin_dout,
    input  logic [7:0]        pin_din,
    output logic              pin_dir,
    output logic [4:0]        pin_ctrl,
    input  logic [7:0]        pin_status,
    input  logic              pin_ack,
    output logic              irq,
    output logic              xfer_req,
    output logic [2:0]        xfer_tag,
    output logic [7:0]        xfer_wdata,
    input  logic              xfer_ready,
    input  logic [7:0]        xfer_rdata
);
    import pport_pkg::*;

    localparam int WIN_REGS = (BASE_ADDR == 16'h03BC) ? 4 : 8;
    localparam int WIN_SHFT = $clog2(WIN_REGS);

    logic [2:0]       ofs;
    logic             hit;
    logic             accept;
    logic             rd_go;
    logic             wr_go;
    logic [REG_W-1:0] ctrl_wr_val;
    logic [REG_W-1:0] status_s;
    logic             ack_s;
    logic             stat_clear;
    logic             epp_start;
    logic             epp_busy;
    logic             epp_done;

    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] ctrl_q;
    logic             dir_q;
    logic             rvalid_q;
    logic [REG_W-1:0] rdata_q;
    logic             xreq_q;
    xfer_tag_t        xtag_q;
    logic [REG_W-1:0] xwdata_q;

    // Window match and register offset; a four-register window has no bit 2
    generate
        if (WIN_REGS == 8) begin : g_win8
            assign ofs = bus_addr[2:0];
        end else begin : g_win4
            assign ofs = {1'b0, bus_addr[1:0]};
        end
    endgenerate
    assign hit = (bus_addr >> WIN_SHFT) == (BASE_ADDR >> WIN_SHFT);

    // Strobes are taken only while no enhanced read is outstanding
    assign accept      = !epp_busy;
    assign rd_go       = bus_rd && hit && accept;
    assign wr_go       = bus_wr && hit && accept;
    assign ctrl_wr_val = bus_wdata | CTRL_FORCED;
    assign stat_clear  = rd_go && bus_byte && (ofs == OFS_STAT);
    assign epp_start   = rd_go && bus_byte && ((ofs == OFS_EADDR) || (ofs == OFS_EDATA));

    pport_sync #(.WIDTH(REG_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_stat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_status),
        .q     (status_s)
    );

    pport_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_ack),
        .q     (ack_s)
    );

    pport_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_s  (ack_s),
        .enable (ctrl_q[CB_ACK_IRQ]),
        .clear  (stat_clear),
        .irq    (irq)
    );

    pport_epp_seq u_epp (
        .clk   (clk),
        .rst_n (rst_n),
        .start (epp_start),
        .ready (xfer_ready),
        .busy  (epp_busy),
        .done  (epp_done)
    );

    // Register writes, read capture and transfer request generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctrl_q   <= CTRL_FORCED;
            dir_q    <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= BUS_FLOAT;
            xreq_q   <= 1'b0;
            xtag_q   <= XF_DATA_WR;
            xwdata_q <= '0;
        end else begin
            rvalid_q <= 1'b0;
            xreq_q   <= 1'b0;
            if (wr_go && bus_byte) begin
                unique case (ofs)
                    OFS_DATA: begin
                        data_q   <= bus_wdata;
                        xreq_q   <= 1'b1;
                        xtag_q   <= XF_DATA_WR;
                        xwdata_q <= bus_wdata;
                    end
                    OFS_CTRL: begin
                        if (ctrl_wr_val != ctrl_q) begin
                            dir_q  <= ctrl_wr_val[CB_REVERSE];
                            ctrl_q <= ctrl_wr_val & ~(REG_W'(1) << CB_REVERSE);
                        end
                    end
                    OFS_EADDR: begin
                        xreq_q   <= 1'b1;
                        xtag_q   <= XF_EADDR_WR;
                        xwdata_q <= bus_wdata;
                    end
                    OFS_EDATA: begin
                        xreq_q   <= 1'b1;
                        xtag_q   <= XF_EDATA_WR;
                        xwdata_q <= bus_wdata;
                    end
                    default: ;
                endcase
            end
            if (rd_go) begin
                if (!bus_byte) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= BUS_FLOAT;
                end else begin
                    unique case (ofs)
                        OFS_DATA: begin
                            rvalid_q <= 1'b1;
                            if (dir_q) begin
                                rdata_q <= pin_din;
                                data_q  <= pin_din;
                            end else begin
                                rdata_q <= data_q;
                            end
                        end
                        OFS_STAT: begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= status_s;
                        end
                        OFS_CTRL: begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= ctrl_q;
                        end
                        OFS_EADDR: begin
                            xreq_q   <= 1'b1;
                            xtag_q   <= XF_EADDR_RD;
                            xwdata_q <= '0;
                        end
                        OFS_EDATA: begin
                            xreq_q   <= 1'b1;
                            xtag_q   <= XF_EDATA_RD;
                            xwdata_q <= '0;
                        end
                        default: begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= BUS_FLOAT;
                        end
                    endcase
                end
            end
        end
    end

    assign bus_rvalid = rvalid_q || epp_done;
    assign bus_rdata  = epp_done ? xfer_rdata : rdata_q;
    assign pin_dout   = data_q;
    assign pin_dir    = dir_q;
    assign pin_ctrl   = ctrl_q[4:0];
    assign xfer_req   = xreq_q;
    assign xfer_tag   = xtag_q;
    assign xfer_wdata = xwdata_q;

    AST_CTRL_FORCED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7:6] == 2'b11); // R6
    AST_CTRL_NO_REVERSE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CB_REVERSE]); // R7
    AST_WIDE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !bus_byte) |=> ($stable(data_q) && $stable(ctrl_q) && $stable(dir_q))); // R2
    AST_PLAIN_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !epp_start) |=> bus_rvalid); // R12
    AST_OUTSIDE_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit && !epp_busy) |=> !rvalid_q); // R1

endmodule

// File: tb/pport_regblock_bench.sv
module pport_regblock_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [15:0] B  = 16'h0378;
    localparam logic [15:0] B2 = 16'h03BC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pin_din = '0, pin_status = '0, xfer_rdata = '0;
    logic pin_ack = 1'b0, xfer_ready = 1'b0;

    logic bus_rvalid, pin_dir, irq, xfer_req;
    logic [7:0] bus_rdata, pin_dout, xfer_wdata;
    logic [4:0] pin_ctrl;
    logic [2:0] xfer_tag;

    logic a_rvalid, a_dir, a_irq, a_req;
    logic [7:0] a_rdata, a_dout, a_wdata;
    logic [4:0] a_ctrl;
    logic [2:0] a_tag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic       seen_req;
    logic [2:0] seen_tag;
    logic [7:0] seen_wd;
    logic       rd_v;
    logic [7:0] rd_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_regblock u_pport_regblock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .pin_dout(pin_dout), .pin_din(pin_din), .pin_dir(pin_dir), .pin_ctrl(pin_ctrl),
        .pin_status(pin_status), .pin_ack(pin_ack), .irq(irq), .xfer_req(xfer_req),
        .xfer_tag(xfer_tag), .xfer_wdata(xfer_wdata), .xfer_ready(xfer_ready), .xfer_rdata(xfer_rdata)
    );

    pport_regblock #(.BASE_ADDR(16'h03BC)) u_pport_regblock_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rvalid(a_rvalid), .bus_rdata(a_rdata),
        .pin_dout(a_dout), .pin_din(pin_din), .pin_dir(a_dir), .pin_ctrl(a_ctrl),
        .pin_status(pin_status), .pin_ack(pin_ack), .irq(a_irq), .xfer_req(a_req),
        .xfer_tag(a_tag), .xfer_wdata(a_wdata), .xfer_ready(xfer_ready), .xfer_rdata(xfer_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic byt);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_byte = byt; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b1;
        seen_req = xfer_req; seen_tag = xfer_tag; seen_wd = xfer_wdata;
    endtask

    task automatic rd(input logic [15:0] a, input logic byt, input logic alt);
        @(negedge clk);
        bus_addr = a; bus_byte = byt; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_byte = 1'b1;
        rd_v = alt ? a_rvalid : bus_rvalid;
        rd_d = alt ? a_rdata : bus_rdata;
    endtask

    task automatic t_reset();
        chk("R12 dout", pin_dout, 8'h00);
        chk("R12 dir", {7'd0, pin_dir}, 8'h00);
        chk("R12 irq", {7'd0, irq}, 8'h00);
        chk("R12 xfer_req", {7'd0, xfer_req}, 8'h00);
        chk("R12 rvalid", {7'd0, bus_rvalid}, 8'h00);
        rd(B + 2, 1'b1, 1'b0);
        chk("R12 ctrl read valid", {7'd0, rd_v}, 8'h01);
        chk("R12 ctrl reset value", rd_d, 8'hC0);
    endtask

    task automatic t_data();
        wr(B, 8'h5A, 1'b1);
        chk("R3 dout", pin_dout, 8'h5A);
        chk("R3 req", {7'd0, seen_req}, 8'h01);
        chk("R3 tag", {5'd0, seen_tag}, 8'h00);
        chk("R3 wdata", seen_wd, 8'h5A);
        rd(B, 1'b1, 1'b0);
        chk("R12 data read valid", {7'd0, rd_v}, 8'h01);
        chk("R4 forward read", rd_d, 8'h5A);
    endtask

    task automatic t_ctrl();
        wr(B + 2, 8'h15, 1'b1);
        chk("R6 pin_ctrl", {3'd0, pin_ctrl}, 8'h15);
        rd(B + 2, 1'b1, 1'b0);
        chk("R6 ctrl readback", rd_d, 8'hD5);
        wr(B + 2, 8'h2A, 1'b1);
        chk("R7 dir reverse", {7'd0, pin_dir}, 8'h01);
        rd(B + 2, 1'b1, 1'b0);
        chk("R7 bit5 cleared", rd_d, 8'hCA);
        pin_din = 8'h3C;
        rd(B, 1'b1, 1'b0);
        chk("R4 reverse read", rd_d, 8'h3C);
        wr(B + 2, 8'h0A, 1'b1);
        chk("R7 equal write keeps dir", {7'd0, pin_dir}, 8'h01);
        wr(B + 2, 8'h00, 1'b1);
        chk("R7 dir forward", {7'd0, pin_dir}, 8'h00);
        chk("R7 pin_ctrl", {3'd0, pin_ctrl}, 8'h00);
        chk("R4 reverse read stored", pin_dout, 8'h3C);
        rd(B, 1'b1, 1'b0);
        chk("R4 forward after reverse", rd_d, 8'h3C);
    endtask

    task automatic t_epp_wr();
        wr(B + 3, 8'h11, 1'b1);
        chk("R8 addr req", {7'd0, seen_req}, 8'h01);
        chk("R8 addr tag", {5'd0, seen_tag}, 8'h01);
        chk("R8 addr wdata", seen_wd, 8'h11);
        wr(B + 4, 8'h22, 1'b1);
        chk("R8 data tag", {5'd0, seen_tag}, 8'h02);
        chk("R8 data wdata", seen_wd, 8'h22);
    endtask

    task automatic t_epp_rd(input logic [2:0] ofs, input logic [2:0] tag, input logic [7:0] val);
        @(negedge clk);
        bus_addr = B + 16'(ofs); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 read req", {7'd0, xfer_req}, 8'h01);
        chk("R9 read tag", {5'd0, xfer_tag}, {5'd0, tag});
        chk("R9 no early valid", {7'd0, bus_rvalid}, 8'h00);
        bus_wr = 1'b1; bus_addr = B; bus_wdata = 8'hEE;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 strobe ignored while waiting", pin_dout, 8'h3C);
        chk("R9 still waiting", {7'd0, bus_rvalid}, 8'h00);
        xfer_rdata = val; xfer_ready = 1'b1;
        #1;
        chk("R9 valid with ready", {7'd0, bus_rvalid}, 8'h01);
        chk("R9 read data", bus_rdata, val);
        @(negedge clk);
        xfer_ready = 1'b0;
        chk("R9 valid ends", {7'd0, bus_rvalid}, 8'h00);
    endtask

    task automatic t_unused();
        wr(B + 5, 8'h99, 1'b1);
        chk("R10 wr5 no req", {7'd0, seen_req}, 8'h00);
        wr(B + 6, 8'h99, 1'b1);
        wr(B + 7, 8'h99, 1'b1);
        chk("R10 dout kept", pin_dout, 8'h3C);
        chk("R10 ctrl kept", {3'd0, pin_ctrl}, 8'h00);
        rd(B + 6, 1'b1, 1'b0);
        chk("R10 read valid", {7'd0, rd_v}, 8'h01);
        chk("R10 read value", rd_d, 8'hFF);
    endtask

    task automatic t_irq();
        @(negedge clk); pin_ack = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 disabled edge dropped", {7'd0, irq}, 8'h00);
        pin_ack = 1'b0;
        repeat (3) @(negedge clk);
        wr(B + 2, 8'h10, 1'b1);
        pin_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 not before third edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R11 set on third edge", {7'd0, irq}, 8'h01);
        pin_ack = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 held", {7'd0, irq}, 8'h01);
        rd(B + 1, 1'b0, 1'b0);
        chk("R2 wide read value", rd_d, 8'hFF);
        chk("R2 wide read keeps irq", {7'd0, irq}, 8'h01);
        rd(B + 1, 1'b1, 1'b0);
        chk("R5 status value", rd_d, 8'hA8);
        chk("R5 irq cleared", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_width();
        wr(B, 8'h77, 1'b0);
        chk("R2 wide write dropped", pin_dout, 8'h3C);
        chk("R2 wide write no req", {7'd0, seen_req}, 8'h00);
    endtask

    task automatic t_decode();
        rd(16'h0380, 1'b1, 1'b0);
        chk("R1 outside no answer", {7'd0, rd_v}, 8'h00);
        wr(16'h0380, 8'h01, 1'b1);
        chk("R1 outside no write", pin_dout, 8'h3C);
        wr(B2, 8'h44, 1'b1);
        chk("R1 alt window data", a_dout, 8'h44);
        chk("R1 main untouched", pin_dout, 8'h3C);
        rd(B2 + 2, 1'b1, 1'b1);
        chk("R1 alt ctrl read", rd_d, 8'hC0);
        rd(B2 + 4, 1'b1, 1'b1);
        chk("R1 alt four-reg window", {7'd0, rd_v}, 8'h00);
    endtask

    initial begin
        pin_status = 8'hA8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data();
        t_ctrl();
        t_epp_wr();
        t_epp_rd(3'd3, 3'd3, 8'h9E);
        t_epp_rd(3'd4, 3'd4, 8'h61);
        t_unused();
        t_irq();
        t_width();
        t_decode();
        summary();
        $finish;
    end

endmodule